// File: doc/BRIEF.md
# SPI Slave Byte Engine with Transmit and Receive Queues

This block is the slave side of an SPI link. Four external pins (serial clock, select, data in, data out) are brought into the system clock domain through a short flop chain, and the clock edges are detected there. One byte is shifted per transfer, most significant bit first. On the chip side the block has a small transmit queue that software fills and a small receive queue that software drains.

Two policy inputs shape each transfer. The transmit policy either consumes the queue head once per byte or only shows it, leaving it in place. The receive policy either stores each completed byte or throws it away. If no transmit byte is waiting, the slave sends back the last byte it received. Three sticky error bits record a transmit underflow, a receive overflow and a select that went away in the middle of a byte. Software clears each bit by writing a one to it. Select polarity, idle clock level and capture phase are inputs, and they must match the master. The serial clock period must be at least eight system clocks.

Top module: `spis_slave`

## Requirements
- R1: With `cfg_tx_pop`=1 and the transmit queue not empty, each byte sends the queue head MSB first and removes it, so back-to-back bytes under one select come out in write order.
- R2: With `cfg_tx_pop`=1 and the transmit queue empty, the byte sent is the most recently completed received byte (0x00 after reset), and `err_flags[0]` (underflow) becomes 1.
- R3: With `cfg_tx_pop`=0, the queue head is sent but stays in the queue, so it is sent again on the next byte.
- R4: With `cfg_tx_pop`=0 and the transmit queue empty, the last received byte is sent and `err_flags[0]` stays 0.
- R5: With `cfg_rx_store`=1, each completed byte is appended to the receive queue. `rx_rd_data` shows the oldest byte and `rx_rd_en` removes it.
- R6: With `cfg_rx_store`=1 and the receive queue full, a newly completed byte is dropped, the queue keeps its contents, and `err_flags[1]` (overflow) becomes 1.
- R7: With `cfg_rx_store`=0, completed bytes never reach the receive queue.
- R8: If select goes inactive after the first bit edge of a byte and before its last sample, `err_flags[2]` (select fault) becomes 1. The partial byte is discarded, and the next byte starts again from bit 7.
- R9: `cfg_ss_low`=1 makes select active when `ss` is 0, and `cfg_ss_low`=0 makes it active when `ss` is 1. Clock edges seen while select is inactive have no effect.
- R10: `cfg_cpol` is the idle level of `sck`. With `cfg_cpha`=0 data is captured on the edge leaving idle and changed on the edge returning to idle. With `cfg_cpha`=1 the roles are swapped. All four combinations transfer correctly.
- R11: Error bits hold until cleared. A one in bit n of `flag_clr` clears `err_flags[n]`, unless a new event for that bit occurs in the same cycle.
- R12: After reset, `err_flags` is 0, both queues are empty, and `tx_full` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_tx_pop | input | 1 | 1: consume transmit head per byte; 0: show it only |
| cfg_rx_store | input | 1 | 1: store received bytes; 0: drop them |
| cfg_ss_low | input | 1 | 1: select active low; 0: active high |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | 0: capture on leaving edge; 1: capture on returning edge |
| sck | input | 1 | Serial clock from master |
| ss | input | 1 | Slave select from master |
| mosi | input | 1 | Serial data from master |
| miso | output | 1 | Serial data to master |
| tx_wr_en | input | 1 | Write strobe into the transmit queue |
| tx_wr_data | input | DW | Byte written into the transmit queue |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_rd_en | input | 1 | Remove the oldest received byte |
| rx_rd_data | output | DW | Oldest received byte |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| flag_clr | input | 3 | Write-one-to-clear strobes for the error bits |
| err_flags | output | 3 | Sticky errors: bit 0 underflow, bit 1 overflow, bit 2 select fault |

## Verification
The bench uses the default build: 8-bit bytes, four-entry queues on both sides and two synchronizer stages. With only four receive entries, the overflow case and the check that the queue kept its contents need just five bytes. A four-entry transmit queue is also enough to show write-order draining across several bytes under one select. A vector table runs all eight combinations of clock polarity, clock phase and select polarity, and directed sequences then cover echo, peek, drop, fault and clearing.

// File: rtl/spis_pkg.sv
package spis_pkg;

  localparam int FLAG_N = 3;
  localparam int FL_UDF = 0;
  localparam int FL_OVF = 1;
  localparam int FL_SSF = 2;

  // An edge leaves idle when the new clock level differs from the idle level.
  function automatic logic f_leaving_idle(input logic idle_lvl, input logic new_lvl);
    return new_lvl != idle_lvl;
  endfunction

  // Select is active when the pin level disagrees with the active-low setting.
  function automatic logic f_sel_active(input logic active_low, input logic pin_lvl);
    return pin_lvl ^ active_low;
  endfunction

endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/spis_fifo.sv
module spis_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [DW-1:0]              wr_data,
  input  logic                       rd_en,
  output logic [DW-1:0]              head,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] count
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_wr, do_rd;

  function automatic logic [AW-1:0] f_step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign do_wr = wr_en & ~full;
  assign do_rd = rd_en & ~empty;
  assign head  = mem[rp];
  assign count = cnt;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= f_step(wp);
      if (do_rd) rp <= f_step(rp);
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/spis_shifter.sv
module spis_shifter
  import spis_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck_s,
  input  logic          mosi_s,
  input  logic          sel_act,
  input  logic          cfg_cpol,
  input  logic          cfg_cpha,
  input  logic [DW-1:0] tx_pick,
  output logic          miso,
  output logic          ev_commit,
  output logic          ev_done,
  output logic          ev_fault,
  output logic [DW-1:0] rx_byte,
  output logic          busy
);

  localparam int BW = (DW > 2) ? $clog2(DW) : 1;

  logic          sck_prev;
  logic          in_byte;
  logic [BW-1:0] bitcnt;
  logic [DW-1:0] txsh, rxsh;
  logic          sck_chg, lead_e, trail_e, samp_e, shft_e;
  logic          do_sample, do_shift;

  assign sck_chg   = sck_s ^ sck_prev;
  assign lead_e    = sel_act & sck_chg &  f_leaving_idle(cfg_cpol, sck_s);
  assign trail_e   = sel_act & sck_chg & ~f_leaving_idle(cfg_cpol, sck_s);
  assign samp_e    = cfg_cpha ? trail_e : lead_e;
  assign shft_e    = cfg_cpha ? lead_e  : trail_e;

  assign ev_commit = lead_e & ~in_byte;
  assign do_sample = samp_e & (in_byte | ev_commit);
  assign do_shift  = shft_e & in_byte & ~ev_commit;
  assign ev_done   = do_sample & (bitcnt == BW'(DW-1));
  assign ev_fault  = ~sel_act & in_byte;
  assign rx_byte   = {rxsh[DW-2:0], mosi_s};
  assign busy      = in_byte;
  assign miso      = in_byte ? txsh[DW-1] : tx_pick[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev <= 1'b0;
      in_byte  <= 1'b0;
      bitcnt   <= '0;
      txsh     <= '0;
      rxsh     <= '0;
    end else begin
      sck_prev <= sck_s;
      if (!sel_act) begin
        in_byte <= 1'b0;
        bitcnt  <= '0;
        rxsh    <= '0;
      end else begin
        if (ev_commit)     txsh <= tx_pick;
        else if (do_shift) txsh <= {txsh[DW-2:0], 1'b0};
        if (do_sample) begin
          rxsh   <= rx_byte;
          bitcnt <= ev_done ? '0 : bitcnt + BW'(1);
        end
        if (ev_done)        in_byte <= 1'b0;
        else if (ev_commit) in_byte <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/spis_slave.sv
module spis_slave
  import spis_pkg::*;
#(
  parameter int DW          = 8,
  parameter int TX_DEPTH    = 4,
  parameter int RX_DEPTH    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_tx_pop,
  input  logic              cfg_rx_store,
  input  logic              cfg_ss_low,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              sck,
  input  logic              ss,
  input  logic              mosi,
  output logic              miso,
  input  logic              tx_wr_en,
  input  logic [DW-1:0]     tx_wr_data,
  output logic              tx_full,
  output logic              tx_empty,
  input  logic              rx_rd_en,
  output logic [DW-1:0]     rx_rd_data,
  output logic              rx_empty,
  output logic              rx_full,
  input  logic [FLAG_N-1:0] flag_clr,
  output logic [FLAG_N-1:0] err_flags
);

  localparam int TX_CW = $clog2(TX_DEPTH+1);
  localparam int RX_CW = $clog2(RX_DEPTH+1);

  logic              sck_s, ss_s, mosi_s, sel_act;
  logic              ev_commit, ev_done, ev_fault, busy;
  logic [DW-1:0]     rx_byte, last_rx, tx_head, tx_pick;
  logic              tx_empty_i, tx_full_i, rx_empty_i, rx_full_i;
  logic              tx_pop, rx_push;
  logic [TX_CW-1:0]  tx_count;
  logic [RX_CW-1:0]  rx_count;
  logic [FLAG_N-1:0] flag_set;

  spis_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sck, ss, mosi}),
    .q     ({sck_s, ss_s, mosi_s})
  );

  assign sel_act = f_sel_active(cfg_ss_low, ss_s);
  assign tx_pick = tx_empty_i ? last_rx : tx_head;

  spis_shifter #(.DW(DW)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck_s     (sck_s),
    .mosi_s    (mosi_s),
    .sel_act   (sel_act),
    .cfg_cpol  (cfg_cpol),
    .cfg_cpha  (cfg_cpha),
    .tx_pick   (tx_pick),
    .miso      (miso),
    .ev_commit (ev_commit),
    .ev_done   (ev_done),
    .ev_fault  (ev_fault),
    .rx_byte   (rx_byte),
    .busy      (busy)
  );

  assign tx_pop  = ev_commit & cfg_tx_pop & ~tx_empty_i;
  assign rx_push = ev_done & cfg_rx_store;

  spis_fifo #(.DW(DW), .DEPTH(TX_DEPTH)) u_txq (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tx_wr_en),
    .wr_data (tx_wr_data),
    .rd_en   (tx_pop),
    .head    (tx_head),
    .empty   (tx_empty_i),
    .full    (tx_full_i),
    .count   (tx_count)
  );

  spis_fifo #(.DW(DW), .DEPTH(RX_DEPTH)) u_rxq (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (rx_push),
    .wr_data (rx_byte),
    .rd_en   (rx_rd_en),
    .head    (rx_rd_data),
    .empty   (rx_empty_i),
    .full    (rx_full_i),
    .count   (rx_count)
  );

  assign tx_full  = tx_full_i;
  assign tx_empty = tx_empty_i;
  assign rx_empty = rx_empty_i;
  assign rx_full  = rx_full_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_rx <= '0;
    else if (ev_done) last_rx <= rx_byte;
  end

  assign flag_set[FL_UDF] = ev_commit & cfg_tx_pop & tx_empty_i;
  assign flag_set[FL_OVF] = rx_push & rx_full_i;
  assign flag_set[FL_SSF] = ev_fault;

  generate
    for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_flags[g] <= 1'b0;
        else        err_flags[g] <= flag_set[g] | (err_flags[g] & ~flag_clr[g]);
      end
    end
  endgenerate

endmodule

// File: rtl/spis_slave_chk.sv
module spis_slave_chk #(
  parameter int TCW = 3,
  parameter int RCW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_tx_pop,
  input logic           cfg_rx_store,
  input logic           tx_wr_en,
  input logic           rx_rd_en,
  input logic           ev_commit,
  input logic           ev_done,
  input logic           busy,
  input logic           tx_empty_i,
  input logic           rx_full_i,
  input logic [TCW-1:0] tx_count,
  input logic [RCW-1:0] rx_count,
  input logic [2:0]     err_flags,
  input logic [2:0]     flag_clr
);

  // R1: a consumed byte lowers the transmit level by one
  p_pop_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_commit && cfg_tx_pop && !tx_empty_i && !tx_wr_en |=> tx_count == ($past(tx_count) - TCW'(1)));

  // R2: underflow only appears after a consuming start with nothing queued
  p_udf_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flags[0]) |-> $past(ev_commit && cfg_tx_pop && tx_empty_i));

  // R3: showing the head leaves the transmit level alone
  p_peek_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_commit && !cfg_tx_pop && !tx_wr_en |=> tx_count == $past(tx_count));

  // R4: showing mode never raises underflow
  p_peek_no_udf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_commit && !cfg_tx_pop && !err_flags[0] |=> !err_flags[0]);

  // R5: a stored byte raises the receive level by one
  p_push_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done && cfg_rx_store && !rx_full_i && !rx_rd_en |=> rx_count == ($past(rx_count) + RCW'(1)));

  // R6: overflow only appears after a completion into a full queue
  p_ovf_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flags[1]) |-> $past(ev_done && cfg_rx_store && rx_full_i));

  // R7: dropping mode leaves the receive level alone
  p_drop_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done && !cfg_rx_store && !rx_rd_en |=> rx_count == $past(rx_count));

  // R8: select fault only appears when a byte was in flight
  p_ssf_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flags[2]) |-> $past(busy));

  // R11: error bits hold without a clear strobe
  p_sticky_udf_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_flags[0] && !flag_clr[0] |=> err_flags[0]);
  p_sticky_ovf_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_flags[1] && !flag_clr[1] |=> err_flags[1]);
  p_sticky_ssf_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_flags[2] && !flag_clr[2] |=> err_flags[2]);

endmodule

bind spis_slave spis_slave_chk #(.TCW(TX_CW), .RCW(RX_CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_tx_pop   (cfg_tx_pop),
  .cfg_rx_store (cfg_rx_store),
  .tx_wr_en     (tx_wr_en),
  .rx_rd_en     (rx_rd_en),
  .ev_commit    (ev_commit),
  .ev_done      (ev_done),
  .busy         (busy),
  .tx_empty_i   (tx_empty_i),
  .rx_full_i    (rx_full_i),
  .tx_count     (tx_count),
  .rx_count     (rx_count),
  .err_flags    (err_flags),
  .flag_clr     (flag_clr)
);

// File: tb/spis_slave_test.sv
module spis_slave_test;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int NVEC       = 8;

  // {cpol, cpha, ss_low, byte to send, byte master sends}
  localparam logic [18:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b1, 8'hA1, 8'h5E},
    {1'b0, 1'b1, 1'b1, 8'hB2, 8'h6D},
    {1'b1, 1'b0, 1'b1, 8'hC3, 8'h7C},
    {1'b1, 1'b1, 1'b1, 8'hD4, 8'h8B},
    {1'b0, 1'b0, 1'b0, 8'hE5, 8'h9A},
    {1'b0, 1'b1, 1'b0, 8'hF6, 8'h19},
    {1'b1, 1'b0, 1'b0, 8'h07, 8'h28},
    {1'b1, 1'b1, 1'b0, 8'h18, 8'h37}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_tx_pop = 1'b1, cfg_rx_store = 1'b1, cfg_ss_low = 1'b1, cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic sck = 1'b0, ss = 1'b1, mosi = 1'b0;
  logic miso;
  logic tx_wr_en = 1'b0;
  logic [7:0] tx_wr_data = 8'h00;
  logic tx_full, tx_empty, rx_empty, rx_full;
  logic rx_rd_en = 1'b0;
  logic [7:0] rx_rd_data;
  logic [2:0] flag_clr = 3'b000;
  logic [2:0] err_flags;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] last_rx = 8'h00;
  logic [7:0] got;

  always #(CLK_PERIOD/2) clk = ~clk;

  spis_slave uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_tx_pop(cfg_tx_pop), .cfg_rx_store(cfg_rx_store), .cfg_ss_low(cfg_ss_low),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .sck(sck), .ss(ss), .mosi(mosi), .miso(miso),
    .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data), .tx_full(tx_full), .tx_empty(tx_empty),
    .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data), .rx_empty(rx_empty), .rx_full(rx_full),
    .flag_clr(flag_clr), .err_flags(err_flags)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input logic cp, input logic ph, input logic sl, input logic pop, input logic st);
    @(negedge clk);
    cfg_ss_low = sl; ss = sl; cfg_tx_pop = pop; cfg_rx_store = st;
    idle(6);
    cfg_cpol = cp; cfg_cpha = ph; sck = cp;
    idle(6);
  endtask

  task automatic sel_on();
    @(negedge clk); ss = ~cfg_ss_low; idle(6);
  endtask

  task automatic sel_off();
    idle(6); ss = cfg_ss_low; idle(6);
  endtask

  task automatic push_tx(input logic [7:0] b);
    @(negedge clk); tx_wr_en = 1'b1; tx_wr_data = b;
    @(negedge clk); tx_wr_en = 1'b0;
  endtask

  task automatic pop_rx();
    @(negedge clk); rx_rd_en = 1'b1;
    @(negedge clk); rx_rd_en = 1'b0;
  endtask

  task automatic clr_flags(input logic [2:0] m);
    @(negedge clk); flag_clr = m;
    @(negedge clk); flag_clr = 3'b000;
  endtask

  // Master side: shifts nbits of out_b MSB first, returns captured bits.
  task automatic xbyte(input logic [7:0] out_b, input int nbits, output logic [7:0] in_b);
    in_b = 8'h00;
    for (int i = 7; i > 7 - nbits; i--) begin
      if (!cfg_cpha) begin
        mosi = out_b[i];
        idle(HALF);
        in_b[i] = miso;
        sck = ~cfg_cpol;
        idle(HALF);
        sck = cfg_cpol;
      end else begin
        sck = ~cfg_cpol;
        mosi = out_b[i];
        idle(HALF);
        in_b[i] = miso;
        sck = cfg_cpol;
        idle(HALF);
      end
    end
    idle(HALF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R12: reset state
    chk("R12 flags", 32'(err_flags), 32'h0);
    chk("R12 tx_empty", 32'(tx_empty), 32'h1);
    chk("R12 tx_full", 32'(tx_full), 32'h0);
    chk("R12 rx_empty", 32'(rx_empty), 32'h1);

    // R1 R5 R9 R10: every mode combination from the vector table
    for (int v = 0; v < NVEC; v++) begin
      set_cfg(VEC[v][18], VEC[v][17], VEC[v][16], 1'b1, 1'b1);
      push_tx(VEC[v][15:8]);
      sel_on();
      xbyte(VEC[v][7:0], 8, got);
      sel_off();
      chk($sformatf("R10 miso vec%0d", v), 32'(got), 32'(VEC[v][15:8]));
      chk($sformatf("R1 tx drained vec%0d", v), 32'(tx_empty), 32'h1);
      chk($sformatf("R5 rx data vec%0d", v), 32'(rx_rd_data), 32'(VEC[v][7:0]));
      chk($sformatf("R9 rx present vec%0d", v), 32'(rx_empty), 32'h0);
      pop_rx();
      last_rx = VEC[v][7:0];
    end
    chk("R12 no errors after table", 32'(err_flags), 32'h0);

    // R2: consuming mode, empty queue echoes last received byte
    set_cfg(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    sel_on();
    xbyte(8'h99, 8, got);
    chk("R2 echo first", 32'(got), 32'(last_rx));
    xbyte(8'h42, 8, got);
    chk("R2 echo second", 32'(got), 32'h99);
    sel_off();
    last_rx = 8'h42;
    chk("R2 underflow flag", 32'(err_flags), 32'h1);
    chk("R5 order first", 32'(rx_rd_data), 32'h99);
    pop_rx();
    chk("R5 order second", 32'(rx_rd_data), 32'h42);
    pop_rx();
    chk("R5 drained", 32'(rx_empty), 32'h1);

    // R11: write-one-to-clear
    clr_flags(3'b001);
    chk("R11 cleared", 32'(err_flags), 32'h0);

    // R1: write order under one select
    push_tx(8'h11);
    push_tx(8'h22);
    sel_on();
    xbyte(8'h01, 8, got);
    chk("R1 first byte", 32'(got), 32'h11);
    xbyte(8'h02, 8, got);
    chk("R1 second byte", 32'(got), 32'h22);
    sel_off();
    last_rx = 8'h02;
    chk("R1 queue empty", 32'(tx_empty), 32'h1);
    pop_rx(); pop_rx();

    // R3 R7: showing mode with dropping receive
    set_cfg(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    push_tx(8'h3C);
    sel_on();
    xbyte(8'h55, 8, got);
    chk("R3 peek first", 32'(got), 32'h3C);
    xbyte(8'h66, 8, got);
    chk("R3 peek repeat", 32'(got), 32'h3C);
    sel_off();
    last_rx = 8'h66;
    chk("R3 head kept", 32'(tx_empty), 32'h0);
    chk("R7 nothing stored", 32'(rx_empty), 32'h1);
    chk("R4 no flag in peek", 32'(err_flags), 32'h0);
    set_cfg(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    sel_on();
    xbyte(8'h77, 8, got);
    sel_off();
    last_rx = 8'h77;
    chk("R3 consumed after switch", 32'(got), 32'h3C);
    chk("R3 empty after switch", 32'(tx_empty), 32'h1);

    // R4: showing mode with empty queue echoes without flag
    set_cfg(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    sel_on();
    xbyte(8'h88, 8, got);
    sel_off();
    chk("R4 echo", 32'(got), 32'h77);
    chk("R4 no underflow", 32'(err_flags), 32'h0);
    last_rx = 8'h88;

    // R6: overflow of the receive queue
    set_cfg(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    sel_on();
    for (int k = 0; k < 4; k++) xbyte(8'h51 + 8'(k), 8, got);
    chk("R6 full", 32'(rx_full), 32'h1);
    chk("R6 no flag before", 32'(err_flags), 32'h0);
    xbyte(8'h55, 8, got);
    sel_off();
    last_rx = 8'h55;
    chk("R6 overflow flag", 32'(err_flags), 32'h2);
    for (int k = 0; k < 4; k++) begin
      chk($sformatf("R6 kept entry %0d", k), 32'(rx_rd_data), 32'(8'h51 + 8'(k)));
      pop_rx();
    end
    chk("R6 drained", 32'(rx_empty), 32'h1);
    clr_flags(3'b010);
    chk("R11 clear overflow", 32'(err_flags), 32'h0);

    // R9: clocks while select inactive do nothing
    xbyte(8'hAA, 8, got);
    chk("R9 inactive ignored", 32'(rx_empty), 32'h1);
    chk("R9 no fault", 32'(err_flags), 32'h0);

    // R8: select dropped mid-byte
    sel_on();
    xbyte(8'hF0, 3, got);
    sel_off();
    chk("R8 fault flag", 32'(err_flags), 32'h4);
    chk("R8 partial dropped", 32'(rx_empty), 32'h1);
    sel_on();
    xbyte(8'h6A, 8, got);
    sel_off();
    chk("R8 realigned", 32'(rx_rd_data), 32'h6A);
    pop_rx();
    clr_flags(3'b100);
    chk("R11 clear fault", 32'(err_flags), 32'h0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule